// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product to a 64-bit signed accumulator. The accumulator is held as a high half and a low half of 32 bits each. Together they form one value, `{accHi, accLo}`. Two operating modes are supported. Long mode multiplies the full 32-bit operands. Word mode multiplies only the signed low 16 bits of each operand.

When the saturation enable is set for an operation, a rule that depends on the mode bounds the stored sum:
- **Long mode** bounds the result to a 48-bit range by forcing the upper bits of the high half.
- **Word mode** clamps the result to the signed 32-bit range. It marks an overflow by writing 1 into the high half.

An operation is started with a one-cycle strobe and finishes two clock edges later with a one-cycle done pulse. A new operation may start on every cycle. Each operation accumulates onto the result of the one before it. Software-style setup of the accumulator uses a synchronous clear and separate load strobes for each half.

Top module: `satMac`

## Requirements
- R1: After reset, both accumulator halves read zero and `doneO` is low.
- R2: In long mode with saturation off (`modeWordI`=0, `satEnI`=0), the full signed 32x32 product, sign-extended to 64 bits, is added to `{accHiO, accLoO}`. The 64-bit sum wraps on overflow.
- R3: In word mode with saturation off (`modeWordI`=1), bits [15:0] of each operand are taken as signed 16-bit values. Their product is added to the accumulator with 64-bit wrap. Operand bits [31:16] have no effect.
- R4: In long mode with saturation on, the low half holds the low 32 bits of the sum. If the 64-bit sum is negative, the high half is the sum's high 32 bits with bits [31:16] forced to 1. Otherwise it is the sum's high 32 bits ANDed with 0x00007FFF.
- R5: In word mode with saturation on, a sum below -2^31 stores high = 0x00000001 and low = 0x80000000.
- R6: In word mode with saturation on, a sum above 0x7FFFFFFF stores high = 0x00000001 and low = 0x7FFFFFFF.
- R7: In word mode with saturation on, a sum within [-2^31, 2^31-1] is stored unchanged as the 64-bit sum.
- R8: Mode, saturation enable and operands are sampled at the clock edge where `startI` is high. The new accumulator value and a one-cycle `doneO` pulse appear after the following edge. Starts on consecutive cycles each produce their own done pulse and chain their sums.
- R9: `clearI` zeroes both halves at the next edge. It takes priority over load strobes and over an operation retiring in the same cycle; that operation's sum is discarded, but its `doneO` still pulses.
- R10: `loadHiI` / `loadLoI` write `loadDataI` into the high / low half at the next edge. An operation retiring in the same cycle as either load is discarded, but its `doneO` still pulses.
- R11: On an edge with no retiring operation, no clear and no load, both halves keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Starts one multiply-accumulate |
| modeWordI | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| satEnI | input | 1 | Applies the mode's saturation rule |
| opAI | input | 32 | First operand |
| opBI | input | 32 | Second operand |
| clearI | input | 1 | Zeroes the accumulator |
| loadHiI | input | 1 | Writes loadDataI into the high half |
| loadLoI | input | 1 | Writes loadDataI into the low half |
| loadDataI | input | 32 | Data for the load strobes |
| accHiO | output | 32 | Accumulator high half |
| accLoO | output | 32 | Accumulator low half |
| doneO | output | 1 | One-cycle pulse when an operation retires |

## Verification
The stimulus includes several kinds of operation, and each kind separates a different class of fault:
- Small operands of mixed sign, in both modes, expose sign-extension errors.
- Word-mode operands with nonzero upper halves show whether bits [31:16] leak into the product.
- Accumulators preloaded near the 32-bit and 64-bit boundaries drive each saturation branch and the wrap path, and also separate the long-mode rule (bit 15 of the high half is kept on negative sums) from a true clamp.
- Back-to-back starts, mixed with clears and loads landing on a retiring operation, show whether chaining and the priority order hold.

A behavioural reference model is compared against the outputs on every cycle of a long randomized run.

// File: rtl/satMacPkg.sv
package satMacPkg;

  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } macMode_e;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic capture;  // sample operands into the product stage
    logic retire;   // write the saturated sum into the accumulator
    logic clear;    // zero both halves
    logic loadHi;   // overwrite the high half
    logic loadLo;   // overwrite the low half
  } macStrobes_t;

endpackage

// File: rtl/satMacCtrl.sv
module satMacCtrl
  import satMacPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic        clearI,
  input  logic        loadHiI,
  input  logic        loadLoI,
  output macStrobes_t strobesO,
  output logic        doneO
);

  logic stageValid;
  logic anyLoad;

  assign anyLoad = loadHiI | loadLoI;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      doneO      <= 1'b0;
    end else begin
      stageValid <= startI;
      doneO      <= stageValid;
    end
  end

  // clear outranks loads, loads outrank a retiring operation
  always_comb begin
    strobesO.capture = startI;
    strobesO.clear   = clearI;
    strobesO.loadHi  = loadHiI & ~clearI;
    strobesO.loadLo  = loadLoI & ~clearI;
    strobesO.retire  = stageValid & ~clearI & ~anyLoad;
  end

endmodule

// File: rtl/satMacDatapath.sv
module satMacDatapath
  import satMacPkg::*;
#(
  parameter int HALF_W    = 32,
  parameter int WORD_W    = 16,
  parameter int LONG_KEEP = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobes_t       strobesI,
  input  logic              modeWordI,
  input  logic              satEnI,
  input  logic [HALF_W-1:0] opAI,
  input  logic [HALF_W-1:0] opBI,
  input  logic [HALF_W-1:0] loadDataI,
  output logic [HALF_W-1:0] accHiO,
  output logic [HALF_W-1:0] accLoO
);

  localparam int ACC_W = 2 * HALF_W;

  // long-mode high-half masks
  localparam logic [HALF_W-1:0] POS_MASK =
    {{(HALF_W - LONG_KEEP){1'b0}}, {LONG_KEEP{1'b1}}};
  localparam logic [HALF_W-1:0] NEG_FORCE =
    {{(HALF_W - LONG_KEEP - 1){1'b1}}, {(LONG_KEEP + 1){1'b0}}};

  // word-mode clamp bounds as 64-bit signed values
  localparam logic signed [ACC_W-1:0] W_MAX =
    {{(HALF_W + 1){1'b0}}, {(HALF_W - 1){1'b1}}};
  localparam logic signed [ACC_W-1:0] W_MIN =
    {{(HALF_W + 1){1'b1}}, {(HALF_W - 1){1'b0}}};
  localparam logic [HALF_W-1:0] SAT_FLAG = HALF_W'(1);
  localparam logic [HALF_W-1:0] LO_MAX   = {1'b0, {(HALF_W - 1){1'b1}}};
  localparam logic [HALF_W-1:0] LO_MIN   = {1'b1, {(HALF_W - 1){1'b0}}};

  // ---------------- stage 1: multiply ----------------
  logic signed [HALF_W-1:0] aLong, bLong;
  logic signed [WORD_W-1:0] aWord, bWord;
  logic signed [ACC_W-1:0]  longProd, wordProd, prodD;

  assign aLong = opAI;
  assign bLong = opBI;
  assign aWord = opAI[WORD_W-1:0];
  assign bWord = opBI[WORD_W-1:0];

  always_comb begin
    longProd = ACC_W'(aLong) * ACC_W'(bLong);
    wordProd = ACC_W'(aWord) * ACC_W'(bWord);
    prodD    = (macMode_e'(modeWordI) == MODE_WORD) ? wordProd : longProd;
  end

  logic signed [ACC_W-1:0] prodQ;
  macMode_e                modeQ;
  logic                    satQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ <= '0;
      modeQ <= MODE_LONG;
      satQ  <= 1'b0;
    end else if (strobesI.capture) begin
      prodQ <= prodD;
      modeQ <= macMode_e'(modeWordI);
      satQ  <= satEnI;
    end
  end

  // ---------------- stage 2: accumulate and saturate ----------------
  logic [HALF_W-1:0]       accHiQ, accLoQ;
  logic signed [ACC_W-1:0] accCur, sum;
  logic [HALF_W-1:0]       sumHi, sumLo;
  logic [HALF_W-1:0]       nextHi, nextLo;

  assign accCur = {accHiQ, accLoQ};
  assign sum    = accCur + prodQ;
  assign sumHi  = sum[ACC_W-1:HALF_W];
  assign sumLo  = sum[HALF_W-1:0];

  always_comb begin
    nextHi = sumHi;
    nextLo = sumLo;
    if (satQ) begin
      if (modeQ == MODE_LONG) begin
        if (sum[ACC_W-1]) nextHi = sumHi | NEG_FORCE;
        else              nextHi = sumHi & POS_MASK;
      end else begin
        if (sum < W_MIN) begin
          nextHi = SAT_FLAG;
          nextLo = LO_MIN;
        end else if (sum > W_MAX) begin
          nextHi = SAT_FLAG;
          nextLo = LO_MAX;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHiQ <= '0;
      accLoQ <= '0;
    end else if (strobesI.clear) begin
      accHiQ <= '0;
      accLoQ <= '0;
    end else begin
      if (strobesI.loadHi) accHiQ <= loadDataI;
      if (strobesI.loadLo) accLoQ <= loadDataI;
      if (strobesI.retire) begin
        accHiQ <= nextHi;
        accLoQ <= nextLo;
      end
    end
  end

  assign accHiO = accHiQ;
  assign accLoO = accLoQ;

endmodule

// File: rtl/satMac.sv
module satMac
  import satMacPkg::*;
#(
  parameter int HALF_W    = 32,
  parameter int WORD_W    = 16,
  parameter int LONG_KEEP = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic              modeWordI,
  input  logic              satEnI,
  input  logic [HALF_W-1:0] opAI,
  input  logic [HALF_W-1:0] opBI,
  input  logic              clearI,
  input  logic              loadHiI,
  input  logic              loadLoI,
  input  logic [HALF_W-1:0] loadDataI,
  output logic [HALF_W-1:0] accHiO,
  output logic [HALF_W-1:0] accLoO,
  output logic              doneO
);

  macStrobes_t strobes;

  satMacCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startI   (startI),
    .clearI   (clearI),
    .loadHiI  (loadHiI),
    .loadLoI  (loadLoI),
    .strobesO (strobes),
    .doneO    (doneO)
  );

  satMacDatapath #(
    .HALF_W    (HALF_W),
    .WORD_W    (WORD_W),
    .LONG_KEEP (LONG_KEEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobesI  (strobes),
    .modeWordI (modeWordI),
    .satEnI    (satEnI),
    .opAI      (opAI),
    .opBI      (opBI),
    .loadDataI (loadDataI),
    .accHiO    (accHiO),
    .accLoO    (accLoO)
  );

endmodule

// File: rtl/satMacChk.sv
module satMacChk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startI,
  input logic              modeWordI,
  input logic              satEnI,
  input logic              clearI,
  input logic              loadHiI,
  input logic              loadLoI,
  input logic [HALF_W-1:0] loadDataI,
  input logic [HALF_W-1:0] accHiO,
  input logic [HALF_W-1:0] accLoO,
  input logic              doneO
);

  AST_START_TO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    startI |=> ##1 doneO);  // R8

  AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> $past(startI, 2));  // R8

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    clearI |=> (accHiO == '0 && accLoO == '0));  // R9

  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (loadHiI && !clearI) |=> accHiO == $past(loadDataI));  // R10

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (loadLoI && !clearI) |=> accLoO == $past(loadDataI));  // R10

  AST_LONG_SAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !$past(modeWordI, 2) && $past(satEnI, 2) &&
     !$past(clearI) && !$past(loadHiI) && !$past(loadLoI))
    |-> (accHiO[HALF_W-1:16] == '1 || accHiO[HALF_W-1:15] == '0));  // R4

  AST_WORD_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && $past(modeWordI, 2) && $past(satEnI, 2) &&
     !$past(clearI) && !$past(loadHiI) && !$past(loadLoI))
    |-> (accHiO == '0 || accHiO == HALF_W'(1) || accHiO == '1));  // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!doneO && !$past(clearI) && !$past(loadHiI) && !$past(loadLoI))
    |-> ($stable(accHiO) && $stable(accLoO)));  // R11

endmodule

bind satMac satMacChk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/satMac_tb.sv
module satMac_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0, modeWordI = 1'b0, satEnI = 1'b0;
  logic [31:0] opAI = '0, opBI = '0, loadDataI = '0;
  logic        clearI = 1'b0, loadHiI = 1'b0, loadLoI = 1'b0;
  logic [31:0] accHiO, accLoO;
  logic        doneO;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  satMac u_dut (
    .clk(clk), .rstN(rstN), .startI(startI), .modeWordI(modeWordI),
    .satEnI(satEnI), .opAI(opAI), .opBI(opBI), .clearI(clearI),
    .loadHiI(loadHiI), .loadLoI(loadLoI), .loadDataI(loadDataI),
    .accHiO(accHiO), .accLoO(accLoO), .doneO(doneO)
  );

  // ---------------- behavioural reference model ----------------
  longint mAcc = 0;
  bit     mDone = 0;
  bit     mS1v = 0, mS1word = 0, mS1sat = 0;
  longint mS1prod = 0;
  string  mTag = "R1";

  always @(posedge clk) begin
    longint p, s;
    logic [63:0] u;
    string t;
    if (!rstN) begin
      mAcc <= 0; mDone <= 0; mS1v <= 0; mS1prod <= 0; mTag <= "R1";
    end else begin
      if (modeWordI)
        p = longint'(shortint'(opAI[15:0])) * longint'(shortint'(opBI[15:0]));
      else
        p = longint'(int'(opAI)) * longint'(int'(opBI));
      if (startI) begin
        mS1prod <= p; mS1word <= modeWordI; mS1sat <= satEnI;
      end
      mS1v  <= startI;
      mDone <= mS1v;
      if (clearI) begin
        mAcc <= 0; mTag <= "R9";
      end else if (loadHiI || loadLoI) begin
        u = mAcc;
        if (loadHiI) u[63:32] = loadDataI;
        if (loadLoI) u[31:0]  = loadDataI;
        mAcc <= longint'(u);
        mTag <= "R10";
      end else if (mS1v) begin
        s = mAcc + mS1prod;
        u = s;
        t = mS1word ? "R3" : "R2";
        if (mS1sat && !mS1word) begin
          t = "R4";
          if (s < 0) u[63:48] = 16'hFFFF;
          else       u[63:47] = '0;
        end else if (mS1sat) begin
          if (s < -64'sd2147483648)      begin u = 64'h00000001_80000000; t = "R5"; end
          else if (s > 64'sd2147483647)  begin u = 64'h00000001_7FFFFFFF; t = "R6"; end
          else t = "R7";
        end
        mAcc <= longint'(u);
        mTag <= t;
      end else begin
        mTag <= "R11";
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [63:0] act, exp;
    act = {accHiO, accLoO};
    exp = mAcc;
    check(act === exp, mTag, act, exp);
    check(doneO === mDone, "R8 done", {63'd0, doneO}, {63'd0, mDone});
  endtask

  task automatic cycle();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleInputs();
    startI = 0; clearI = 0; loadHiI = 0; loadLoI = 0;
  endtask

  task automatic op(input bit word, input bit sat, input logic [31:0] a,
                    input logic [31:0] b);
    startI = 1; modeWordI = word; satEnI = sat; opAI = a; opBI = b;
    cycle();
    idleInputs();
  endtask

  task automatic setAcc(input logic [31:0] hi, input logic [31:0] lo);
    loadHiI = 1; loadDataI = hi; cycle(); idleInputs();
    loadLoI = 1; loadDataI = lo; cycle(); idleInputs();
  endtask

  task automatic drain();
    cycle(); cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check({accHiO, accLoO} === 64'd0, "R1 acc", {accHiO, accLoO}, 64'd0);
    check(doneO === 1'b0, "R1 done", {63'd0, doneO}, 64'd0);

    // R2: long mode, small mixed signs, back-to-back
    op(0, 0, 32'd7, -32'sd3);
    op(0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    op(0, 0, 32'h80000000, 32'h80000000);
    drain();
    // R2: wrap across the 64-bit boundary
    setAcc(32'h7FFFFFFF, 32'hFFFFFFFF);
    op(0, 0, 32'd1, 32'd1);
    drain();

    // R3: word mode, upper operand bits must be ignored
    clearI = 1; cycle(); idleInputs();
    op(1, 0, 32'hABCD8000, 32'h12340002);
    op(1, 0, 32'hFFFF7FFF, 32'h00007FFF);
    drain();

    // R4: long saturation, positive and negative sums
    clearI = 1; cycle(); idleInputs();
    op(0, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    drain();
    check({accHiO, accLoO} === 64'h00007FFF_00000001, "R4 const",
          {accHiO, accLoO}, 64'h00007FFF_00000001);
    setAcc(32'h00008000, 32'h0);
    op(0, 1, 32'h7FFFFFFF, 32'h80000000);
    drain();

    // R6: word saturation above the 32-bit range
    setAcc(32'h0, 32'h7FFFFFF0);
    op(1, 1, 32'd4, 32'd4);
    drain();
    check({accHiO, accLoO} === 64'h00000001_7FFFFFFF, "R6 const",
          {accHiO, accLoO}, 64'h00000001_7FFFFFFF);
    // R5: below the range
    setAcc(32'hFFFFFFFF, 32'h80000000);
    op(1, 1, 32'hFFFF, 32'd1);
    drain();
    // R7: in range
    setAcc(32'hFFFFFFFF, 32'hFFFFFF00);
    op(1, 1, 32'd3, 32'd5);
    drain();

    // R9: clear lands on a retiring operation
    setAcc(32'h0, 32'd100);
    op(0, 0, 32'd2, 32'd3);
    clearI = 1; cycle(); idleInputs();
    drain();
    // R10: load lands on a retiring operation
    op(0, 0, 32'd2, 32'd3);
    loadLoI = 1; loadDataI = 32'h55; cycle(); idleInputs();
    drain();

    // randomized back-to-back mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      startI    = (r < 70);
      modeWordI = $urandom_range(0, 1);
      satEnI    = $urandom_range(0, 1);
      opAI      = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom;
      opBI      = ($urandom_range(0, 3) == 0) ? -$urandom_range(0, 15) : $urandom;
      clearI    = ($urandom_range(0, 49) == 0);
      loadHiI   = ($urandom_range(0, 29) == 0);
      loadLoI   = ($urandom_range(0, 29) == 0);
      loadDataI = ($urandom_range(0, 1) == 0) ? $urandom : {31'd0, 1'b1} - $urandom_range(0, 2);
      cycle();
    end
    idleInputs();
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule